// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers 96 level-sensitive interrupt request lines, arranged in three banks of 32, and presents one of them at a time to a processor on a single interrupt output. Software reaches it through a simple synchronous register bus. The bus has a byte address, write data, a write strobe, a read strobe and registered read data. Each bank has a mask that software changes with atomic write-one-to-set and write-one-to-clear registers. A per-bank pending view shows which unmasked lines are asserted.

When some unmasked line is asserted, the controller latches the lowest-numbered one and raises the interrupt output. Software reads the latched number. The number is reported with a spurious flag when the source has gone away or has been masked in the meantime. The controller moves on only after software writes the new-interrupt agreement. A software-triggered reset masks every source and reports when it is complete. The core is a three-state sequencer:
- ST_SRST (reset in progress) goes to ST_IDLE once its cycle count runs out.
- ST_IDLE (nothing latched) goes to ST_ACTIVE when any unmasked line is pending, latching the winner.
- ST_ACTIVE (source latched) goes to ST_IDLE on an agreement write.
- Any state goes to ST_SRST on a soft-reset request or a hardware reset.

Top module: `irq_ctrl`

## Requirements
- R1: After hardware reset every source is masked and `irq_o` is low. The revision register at byte 0x00 reads 0x21, with the major version in bits 7:4 and the minor version in bits 3:0.
- R2: A masked source never raises `irq_o`, even while its request line is held high.
- R3: For bank n, writing ones to byte 0x8C+0x20·n masks those bits and writing ones to byte 0x88+0x20·n unmasks them. Zero bits leave the mask unchanged. Reading either address returns that bank's current mask, where 1 means masked.
- R4: The pending register of bank n at byte 0x98+0x20·n reads the request lines of that bank ANDed with the inverse of its mask. Source s sits in bank s/32 at bit s%32.
- R5: When several unmasked sources are pending while the sequencer is idle, the lowest-numbered one is latched. Its number appears in bits 6:0 of the source register at byte 0x40.
- R6: The latched source is kept until a write to the control register at byte 0x48 with bit 0 set. A control write with bit 0 clear has no effect. After release, the next pending source is presented.
- R7: Bits 31:7 of the source register read all ones when nothing is latched, or when the latched source is no longer asserted or is now masked. They read zero otherwise. `irq_o` is high exactly when a latched source is still pending.
- R8: Writing the system configuration register at byte 0x10 with bit 1 set starts a soft reset. The soft reset masks every source, drops the latched source and clears autoidle. Bit 0 of the status register at byte 0x14 reads 0 while the reset runs (SRST_CYCLES cycles, also after hardware reset) and 1 afterwards. Mask writes during the reset are ignored.
- R9: Bit 0 of the configuration register is an autoidle bit that reads back as written. Bit 1 always reads 0.
- R10: Read data appears on `bus_rdata` one clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | 96 | Level-sensitive request lines, bit s is source s |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The checker watches four properties on every cycle. `irq_o` is never high without some unmasked asserted line. A latched source stays fixed until the agreement. Every latch picks a source that was pending with no lower-numbered pending source. Zero-valued mask writes and soft reset leave the mask in the state they should. The bench scenarios are needed for the address decode and register encodings: the spurious field value, revision, pending and mask readback. They also cover the exact sequence of sources presented across several agreements, and the status bit timing around a soft reset.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DW = 32;

    localparam logic [7:0] OFF_REV    = 8'h00;
    localparam logic [7:0] OFF_CFG    = 8'h10;
    localparam logic [7:0] OFF_STAT   = 8'h14;
    localparam logic [7:0] OFF_SRC    = 8'h40;
    localparam logic [7:0] OFF_CTRL   = 8'h48;
    localparam logic [7:0] OFF_MCLR0  = 8'h88;
    localparam logic [7:0] OFF_MSET0  = 8'h8C;
    localparam logic [7:0] OFF_PEND0  = 8'h98;
    localparam int         BANK_STEP  = 32;

    typedef enum logic [1:0] {
        ST_SRST   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ACTIVE = 2'd2
    } seq_state_t;

    function automatic logic [7:0] clr_addr(input int b);
        return OFF_MCLR0 + 8'(b * BANK_STEP);
    endfunction

    function automatic logic [7:0] set_addr(input int b);
        return OFF_MSET0 + 8'(b * BANK_STEP);
    endfunction

    function automatic logic [7:0] pend_addr(input int b);
        return OFF_PEND0 + 8'(b * BANK_STEP);
    endfunction

endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_all,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] lines,
    output logic [W-1:0] mask,
    output logic [W-1:0] pend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (hold_all) begin
            mask <= '1;
        end else if (set_we) begin
            mask <= mask | wdata;
        end else if (clr_we) begin
            mask <= mask & ~wdata;
        end
    end

    assign pend = lines & ~mask;

endmodule

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
    parameter int N   = 96,
    parameter int IDW = 7
) (
    input  logic [N-1:0]   req,
    output logic           any,
    output logic [IDW-1:0] id
);

    always_comb begin
        any = |req;
        id  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                id = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
    import irqc_pkg::*;
#(
    parameter int N        = 96,
    parameter int IDW      = 7,
    parameter int SRST_CYC = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           srst_req,
    input  logic           agree,
    input  logic           any_pend,
    input  logic [IDW-1:0] win_id,
    input  logic [N-1:0]   pend_vec,
    output seq_state_t     state,
    output logic [IDW-1:0] latched_id,
    output logic           busy,
    output logic           irq_o
);

    localparam int CW = $clog2(SRST_CYC + 1);

    seq_state_t    nxt;
    logic [CW-1:0] cnt;
    logic [N-1:0]  shifted;
    logic          lat_pend;

    always_comb begin
        nxt = state;
        if (srst_req) begin
            nxt = ST_SRST;
        end else begin
            unique case (state)
                ST_SRST:   if (cnt == CW'(SRST_CYC - 1)) nxt = ST_IDLE;
                ST_IDLE:   if (any_pend) nxt = ST_ACTIVE;
                ST_ACTIVE: if (agree) nxt = ST_IDLE;
                default:   nxt = ST_SRST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_SRST;
            cnt        <= '0;
            latched_id <= '0;
        end else begin
            state <= nxt;
            if (srst_req) begin
                cnt        <= '0;
                latched_id <= '0;
            end else begin
                if (state == ST_SRST) cnt <= cnt + 1'b1;
                if (state == ST_IDLE && any_pend) latched_id <= win_id;
            end
        end
    end

    assign shifted  = pend_vec >> latched_id;
    assign lat_pend = shifted[0];

    always_comb begin
        busy  = 1'b0;
        irq_o = 1'b0;
        unique case (state)
            ST_SRST:   busy  = 1'b1;
            ST_IDLE:   irq_o = 1'b0;
            ST_ACTIVE: irq_o = lat_pend;
            default:   busy  = 1'b1;
        endcase
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
#(
    parameter int         NUM_SRC     = 96,
    parameter int         BANK_W      = 32,
    parameter int         SRST_CYCLES = 4,
    parameter logic [3:0] REV_MAJOR   = 4'h2,
    parameter logic [3:0] REV_MINOR   = 4'h1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_we,
    input  logic               bus_re,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_lines,
    output logic               irq_o
);

    localparam int NB  = NUM_SRC / BANK_W;
    localparam int IDW = $clog2(NUM_SRC);

    logic [NB-1:0][BANK_W-1:0] mask_bank;
    logic [NB-1:0][BANK_W-1:0] pend_bank;
    logic [NB-1:0]             set_we;
    logic [NB-1:0]             clr_we;
    logic [NUM_SRC-1:0]        mask_all;
    logic [NUM_SRC-1:0]        pend_all;
    logic                      any_pend;
    logic [IDW-1:0]            win_id;
    logic [IDW-1:0]            latched_id;
    seq_state_t                state;
    logic                      busy;
    logic                      agree;
    logic                      srst_req;
    logic                      mask_we_any;
    logic                      autoidle;
    logic [31:0]               rd_next;

    assign agree       = bus_we && (bus_addr == OFF_CTRL) && bus_wdata[0];
    assign srst_req    = bus_we && (bus_addr == OFF_CFG) && bus_wdata[1];
    assign mask_we_any = |set_we || |clr_we;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign set_we[b] = bus_we && (bus_addr == set_addr(b));
        assign clr_we[b] = bus_we && (bus_addr == clr_addr(b));

        irqc_mask_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold_all (busy),
            .set_we   (set_we[b]),
            .clr_we   (clr_we[b]),
            .wdata    (bus_wdata[BANK_W-1:0]),
            .lines    (irq_lines[b*BANK_W +: BANK_W]),
            .mask     (mask_bank[b]),
            .pend     (pend_bank[b])
        );

        assign mask_all[b*BANK_W +: BANK_W] = mask_bank[b];
        assign pend_all[b*BANK_W +: BANK_W] = pend_bank[b];
    end

    irqc_lowest #(.N(NUM_SRC), .IDW(IDW)) u_pick (
        .req (pend_all),
        .any (any_pend),
        .id  (win_id)
    );

    irqc_seq #(.N(NUM_SRC), .IDW(IDW), .SRST_CYC(SRST_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_req   (srst_req),
        .agree      (agree),
        .any_pend   (any_pend),
        .win_id     (win_id),
        .pend_vec   (pend_all),
        .state      (state),
        .latched_id (latched_id),
        .busy       (busy),
        .irq_o      (irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            autoidle <= 1'b0;
        end else if (srst_req) begin
            autoidle <= 1'b0;
        end else if (bus_we && bus_addr == OFF_CFG) begin
            autoidle <= bus_wdata[0];
        end
    end

    always_comb begin
        rd_next = '0;
        case (bus_addr)
            OFF_REV:  rd_next = {24'h0, REV_MAJOR, REV_MINOR};
            OFF_CFG:  rd_next = {30'h0, 1'b0, autoidle};
            OFF_STAT: rd_next = {31'h0, !busy};
            OFF_SRC:  rd_next = {{(32 - IDW){!irq_o}}, latched_id};
            default: begin
                for (int b = 0; b < NB; b++) begin
                    if (bus_addr == clr_addr(b) || bus_addr == set_addr(b))
                        rd_next = 32'(mask_bank[b]);
                    if (bus_addr == pend_addr(b))
                        rd_next = 32'(pend_bank[b]);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int N   = 96,
    parameter int IDW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           irq_o,
    input  logic [N-1:0]   irq_lines,
    input  logic [N-1:0]   mask_all,
    input  logic [N-1:0]   pend_all,
    input  seq_state_t     state,
    input  logic [IDW-1:0] latched_id,
    input  logic           busy,
    input  logic           agree,
    input  logic           srst_req,
    input  logic           any_pend,
    input  logic           mask_we_any,
    input  logic [31:0]    bus_wdata
);

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((irq_lines & ~mask_all) != '0)); // R2

    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we_any && bus_wdata == 32'h0 && !busy && !srst_req) |=> $stable(mask_all)); // R3

    AST_SRST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (&mask_all)); // R8

    AST_HOLD_UNTIL_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && !agree && !srst_req) |=> (state == ST_ACTIVE && $stable(latched_id))); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ACTIVE) |-> !irq_o); // R7

    AST_LOWEST_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && any_pend && !srst_req) |=>
            ((($past(pend_all) >> latched_id) & N'(1)) != '0 &&
             ($past(pend_all) & ((N'(1) << latched_id) - N'(1))) == '0)); // R5

endmodule

bind irq_ctrl irqc_checker #(.N(NUM_SRC), .IDW(IDW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_o       (irq_o),
    .irq_lines   (irq_lines),
    .mask_all    (mask_all),
    .pend_all    (pend_all),
    .state       (state),
    .latched_id  (latched_id),
    .busy        (busy),
    .agree       (agree),
    .srst_req    (srst_req),
    .any_pend    (any_pend),
    .mask_we_any (mask_we_any),
    .bus_wdata   (bus_wdata)
);

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [95:0] irq_lines = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    irq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .irq_lines (irq_lines),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq low after reset", 32'(irq_o), 32'h0);
        rd(8'h14, d); chk("R8 status done after reset", d, 32'h1);
        rd(8'h00, d); chk("R1 revision", d, 32'h21);
        rd(8'h8C, d); chk("R1 bank0 masked", d, 32'hFFFF_FFFF);
        rd(8'hC8, d); chk("R1 bank2 masked", d, 32'hFFFF_FFFF);
        idle(1);
        chk("R10 rdata holds without read", bus_rdata, 32'hFFFF_FFFF);
    endtask

    task automatic t_masked();
        logic [31:0] d;
        irq_lines[5] = 1'b1; irq_lines[40] = 1'b1;
        idle(3);
        chk("R2 masked line silent", 32'(irq_o), 32'h0);
        rd(8'h98, d); chk("R4 pending bank0 all masked", d, 32'h0);
    endtask

    task automatic t_unmask();
        logic [31:0] d;
        wr(8'h88, 32'h0000_0020);
        idle(3);
        chk("R2 unmasked raises irq", 32'(irq_o), 32'h1);
        rd(8'h40, d); chk("R5 source 5 latched", d, 32'h0000_0005);
        rd(8'h98, d); chk("R4 pending bank0", d, 32'h0000_0020);
        rd(8'h88, d); chk("R3 mask readback after clear", d, 32'hFFFF_FFDF);
    endtask

    task automatic t_sequence();
        logic [31:0] d;
        irq_lines[35] = 1'b1; irq_lines[70] = 1'b1;
        wr(8'hA8, 32'hFFFF_FFFF);
        wr(8'hC8, 32'h0000_0040);
        idle(2);
        rd(8'h40, d); chk("R6 still holds source 5", d, 32'h0000_0005);
        irq_lines[5] = 1'b0;
        idle(2);
        chk("R7 irq drops when latched line falls", 32'(irq_o), 32'h0);
        rd(8'h40, d); chk("R7 spurious on deasserted source", d, 32'hFFFF_FF85);
        wr(8'h48, 32'h1);
        idle(3);
        rd(8'h40, d); chk("R5 lowest of 35/40/70", d, 32'h0000_0023);
        chk("R6 irq after agreement", 32'(irq_o), 32'h1);
        wr(8'h48, 32'h0);
        irq_lines[35] = 1'b0;
        idle(3);
        rd(8'h40, d); chk("R6 bit0-clear control ignored", d, 32'hFFFF_FFA3);
        wr(8'h48, 32'h1);
        idle(3);
        rd(8'h40, d); chk("R6 next source 40", d, 32'h0000_0028);
        wr(8'hAC, 32'h0000_0100);
        idle(2);
        chk("R2 irq drops when latched source masked", 32'(irq_o), 32'h0);
        rd(8'h40, d); chk("R7 spurious on masked source", d, 32'hFFFF_FFA8);
        wr(8'h48, 32'h1);
        idle(3);
        rd(8'h40, d); chk("R5 source 70", d, 32'h0000_0046);
        rd(8'hD8, d); chk("R4 pending bank2", d, 32'h0000_0040);
    endtask

    task automatic t_zero_writes();
        logic [31:0] d;
        wr(8'hCC, 32'h0);
        wr(8'hC8, 32'h0);
        rd(8'hCC, d); chk("R3 zero writes keep bank2 mask", d, 32'hFFFF_FFBF);
        rd(8'hAC, d); chk("R3 bank1 mask after set", d, 32'h0000_0100);
    endtask

    task automatic t_autoidle();
        logic [31:0] d;
        wr(8'h10, 32'h1);
        rd(8'h10, d); chk("R9 autoidle readback", d, 32'h1);
    endtask

    task automatic t_soft_reset();
        logic [31:0] d;
        wr(8'h10, 32'h2);
        rd(8'h14, d); chk("R8 status busy during soft reset", d, 32'h0);
        wr(8'h88, 32'hFFFF_FFFF);
        idle(10);
        rd(8'h14, d); chk("R8 status done after soft reset", d, 32'h1);
        rd(8'h10, d); chk("R8 R9 config cleared", d, 32'h0);
        rd(8'h8C, d); chk("R8 bank0 write during reset ignored", d, 32'hFFFF_FFFF);
        rd(8'hA8, d); chk("R8 bank1 masked", d, 32'hFFFF_FFFF);
        chk("R8 irq low after soft reset", 32'(irq_o), 32'h0);
        rd(8'h40, d); chk("R7 nothing latched reads spurious", d, 32'hFFFF_FF80);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(10);
        t_reset();
        t_masked();
        t_unmask();
        t_sequence();
        t_zero_writes();
        t_autoidle();
        t_soft_reset();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule